// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is the target side of a two-wire serial bus that behaves like a byte-wide serial EEPROM. A fast system clock samples the clock and data lines. The block pulls the data line low through an enable output and otherwise leaves it released. The block holds two memory spaces, and the select byte of a transaction chooses between them:

- a writable main byte array, whose depth is set by a parameter;
- a 64-byte read-only information page, whose first 16 bytes form a factory unique identifier.

A write transaction carries two address bytes and then one or more data bytes, which go into a one-page staging buffer. The bytes are committed to the main array by a timed internal write cycle that starts at the Stop condition. While that cycle runs, the target answers no select, so the controller can find the end of the write by polling. A strap-level write-inhibit input blocks the write cycle.

Reads come in three forms:

- a current-address read, from the internal address counter;
- a random read, which is an address-only write followed by a repeated Start and a read select;
- a sequential read, where the controller acknowledges each byte to receive the next one.

Top module: `eeprom_target`

## Requirements
- R1: The select byte is sent MSB first. Bits 7..4 must be 1010 (main array) or 1011 (information page), bits 3..1 must equal `chip_sel[2:0]`, and bit 0 is 1 for a read and 0 for a write. A matching select is acknowledged by driving `sda_oe` high through the ninth clock. Any other select leaves SDA released and is ignored until the next Start.
- R2: After an acknowledged write select, the target acknowledges two address bytes, high byte first. The address is the low `ADDR_W` bits of that 16-bit value.
- R3: Each data byte of a write goes to the page offset given by the low 6 address bits. The offset then increments and wraps from 63 to 0, while the upper address bits stay fixed. A write can therefore carry up to 64 bytes into one page.
- R4: A write cycle starts only at a Stop that follows at least one data byte aimed at the main array. A repeated Start after data bytes discards them.
- R5: The write cycle lasts exactly `WCYC` system clocks. During it, every select goes unacknowledged. After it, a select is acknowledged again.
- R6: When `wr_inhibit` is high at the Stop, no write cycle starts and the array keeps its contents.
- R7: The information page never changes. Writes to the 1011 space are acknowledged but discarded, and no write cycle starts. Byte i of the page reads as ((i*0x3B) mod 256) XOR `UID_SEED` for i < 16 (the unique identifier) and as 0xFF for 16 <= i < 64.
- R8: A random read returns the byte at the address just written. After an address-only write and a repeated Start, the read select must repeat bits 7..1 of the write select, or it is not acknowledged.
- R9: A current-address read returns the byte at the address counter. The counter increments after every byte read. In the main array it wraps from 2^ADDR_W-1 to 0; in the information page it wraps within the 64 bytes.
- R10: In a sequential read, a controller acknowledge after a byte gets the next byte. A no-acknowledge makes the target release SDA and wait for Stop or Start.
- R11: After reset, `sda_oe` is low and no write cycle is running.
- R12: The target changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line (wired level) |
| sda_oe | output | 1 | High pulls SDA low |
| chip_sel | input | 3 | Strap value the select byte must match |
| wr_inhibit | input | 1 | High blocks the write cycle |

## Verification
A wrong address counter or a wrong page offset shows up as wrong read data on the very next read byte, so the bench compares every returned byte with a behavioural byte model. A write-cycle timer that is stuck or mistimed shows up on the first polling select after a Stop: the select is acknowledged too early or not at all. If the dummy-write tracking or the buffer discard goes wrong, the bench sees it at the acknowledge bit of the following select, or in the first read-back after the transaction.

// File: rtl/eet_pkg.sv
package eet_pkg;

    localparam logic [3:0] SEL_MAIN  = 4'b1010;
    localparam logic [3:0] SEL_INFO  = 4'b1011;
    localparam int         PAGE_W    = 6;
    localparam int         PAGE_BYTES = 1 << PAGE_W;
    localparam int         UID_BYTES = 16;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEL,
        PH_AHI,
        PH_ALO,
        PH_WDATA,
        PH_RDATA
    } phase_e;

    typedef struct packed {
        logic [3:0] space;
        logic [2:0] chip;
        logic       rd;
    } sel_t;

    // Read-only content of the information page; the first bytes are the identifier.
    function automatic logic [7:0] info_byte(input logic [PAGE_W-1:0] idx,
                                             input logic [7:0] seed);
        logic [7:0] prod;
        prod = 8'(idx) * 8'h3B;
        if (int'(idx) < UID_BYTES) return prod ^ seed;
        return 8'hFF;
    endfunction

endpackage

// File: rtl/eet_line_mon.sv
module eet_line_mon (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_sync, sda_sync;
    logic       scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_d    <= scl_sync[1];
            sda_d    <= sda_sync[1];
        end
    end

    assign scl_s     = scl_sync[1];
    assign sda_s     = sda_sync[1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & ~sda_s & sda_d;
    assign stop_det  = scl_s & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/eet_page_buf.sv
module eet_page_buf
    import eet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);
    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst)        mask_q <= '0;
        else if (clr)   mask_q <= '0;
        else if (wr_en) mask_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_idx] <= wr_data;
    end

    assign rd_data  = data_q[rd_idx];
    assign rd_valid = mask_q[rd_idx];
endmodule

// File: rtl/eet_array.sv
module eet_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eet_wcycle.sv
module eet_wcycle
    import eet_pkg::*;
#(
    parameter int WCYC = 500000   // must be at least PAGE_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    output logic              busy,
    output logic              commit_en,
    output logic [PAGE_W-1:0] commit_idx
);
    localparam int CW = $clog2(WCYC + 1);

    logic [CW-1:0]   left_q;
    logic [PAGE_W:0] idx_q;

    assign busy = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
            idx_q  <= '0;
        end else if (launch && !busy) begin
            left_q <= CW'(WCYC);
            idx_q  <= '0;
        end else if (busy) begin
            left_q <= left_q - CW'(1);
            if (!idx_q[PAGE_W]) idx_q <= idx_q + (PAGE_W+1)'(1);
        end
    end

    assign commit_en  = busy & ~idx_q[PAGE_W];
    assign commit_idx = idx_q[PAGE_W-1:0];
endmodule

// File: rtl/eeprom_target.sv
module eeprom_target
    import eet_pkg::*;
#(
    parameter int         ADDR_W   = 11,
    parameter int         WCYC     = 500000,
    parameter logic [7:0] UID_SEED = 8'hA5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] chip_sel,
    input  logic       wr_inhibit
);
    localparam int HI_W  = ADDR_W - 8;
    localparam int PG_HI = ADDR_W - PAGE_W;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    eet_line_mon u_line (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    phase_e            phase_q;
    logic [3:0]        bit_q;
    logic [7:0]        shin_q, shout_q;
    logic              sda_oe_q;
    logic [ADDR_W-1:0] addr_q, next_rd;
    logic [HI_W-1:0]   hi_q;
    logic              info_q, rd_q, chk_q, wpend_q, m_ack_q;
    logic [6:0]        sel7_q;
    logic [PG_HI-1:0]  wpage_q;

    logic              busy, commit_en, launch, byte_done, sel_ok;
    logic [PAGE_W-1:0] commit_idx;
    logic [7:0]        buf_data, arr_rdata, rdata;
    logic              buf_valid;
    sel_t              sel;

    // Decoded select byte and its acceptance.
    assign sel    = sel_t'(shin_q);
    assign sel_ok = (sel.space == SEL_MAIN || sel.space == SEL_INFO)
                  && (sel.chip == chip_sel) && !busy
                  && !(chk_q && sel.rd && (shin_q[7:1] != sel7_q));

    assign byte_done = scl_fall && (bit_q == 4'd8) && (phase_q != PH_IDLE)
                     && !start_det && !stop_det;

    assign launch = stop_det && (phase_q == PH_WDATA) && wpend_q && !info_q
                  && !wr_inhibit && !busy;

    always_comb begin
        next_rd = addr_q + ADDR_W'(1);
        if (info_q) next_rd = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
    end

    assign rdata = info_q ? info_byte(addr_q[PAGE_W-1:0], UID_SEED) : arr_rdata;

    eet_page_buf u_buf (
        .clk(clk), .rst(rst),
        .clr(byte_done && phase_q == PH_ALO),
        .wr_en(byte_done && phase_q == PH_WDATA),
        .wr_idx(addr_q[PAGE_W-1:0]), .wr_data(shin_q),
        .rd_idx(commit_idx), .rd_data(buf_data), .rd_valid(buf_valid)
    );

    eet_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .we(commit_en && buf_valid),
        .waddr({wpage_q, commit_idx}), .wdata(buf_data),
        .raddr(addr_q), .rdata(arr_rdata)
    );

    eet_wcycle #(.WCYC(WCYC)) u_wcyc (
        .clk(clk), .rst(rst), .launch(launch), .busy(busy),
        .commit_en(commit_en), .commit_idx(commit_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            bit_q    <= '0;
            shin_q   <= '0;
            shout_q  <= '0;
            sda_oe_q <= 1'b0;
            addr_q   <= '0;
            hi_q     <= '0;
            info_q   <= 1'b0;
            rd_q     <= 1'b0;
            chk_q    <= 1'b0;
            wpend_q  <= 1'b0;
            m_ack_q  <= 1'b0;
            sel7_q   <= '0;
            wpage_q  <= '0;
        end else if (start_det) begin
            // A restart straight after an address phase makes the next read a random read.
            chk_q    <= (phase_q == PH_AHI) || (phase_q == PH_ALO) || (phase_q == PH_WDATA);
            phase_q  <= PH_SEL;
            bit_q    <= '0;
            sda_oe_q <= 1'b0;
            wpend_q  <= 1'b0;
        end else if (stop_det) begin
            if (launch) wpage_q <= addr_q[ADDR_W-1:PAGE_W];
            phase_q  <= PH_IDLE;
            sda_oe_q <= 1'b0;
            chk_q    <= 1'b0;
            wpend_q  <= 1'b0;
        end else if (phase_q != PH_IDLE) begin
            if (scl_rise) begin
                if (bit_q < 4'd8) shin_q  <= {shin_q[6:0], sda_s};
                else              m_ack_q <= ~sda_s;
                bit_q <= bit_q + 4'd1;
            end else if (scl_fall) begin
                if (bit_q == 4'd8) begin
                    unique case (phase_q)
                        PH_SEL: begin
                            if (sel_ok) begin
                                sda_oe_q <= 1'b1;
                                info_q   <= (sel.space == SEL_INFO);
                                rd_q     <= sel.rd;
                                sel7_q   <= shin_q[7:1];
                            end else begin
                                phase_q  <= PH_IDLE;
                            end
                        end
                        PH_AHI: begin
                            hi_q     <= shin_q[HI_W-1:0];
                            sda_oe_q <= 1'b1;
                        end
                        PH_ALO: begin
                            addr_q   <= {hi_q, shin_q};
                            wpend_q  <= 1'b0;
                            sda_oe_q <= 1'b1;
                        end
                        PH_WDATA: begin
                            addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + PAGE_W'(1);
                            wpend_q  <= 1'b1;
                            sda_oe_q <= 1'b1;
                        end
                        PH_RDATA: sda_oe_q <= 1'b0;
                        default: ;
                    endcase
                end else if (bit_q == 4'd9) begin
                    bit_q    <= '0;
                    sda_oe_q <= 1'b0;
                    unique case (phase_q)
                        PH_SEL: begin
                            if (rd_q) begin
                                phase_q  <= PH_RDATA;
                                shout_q  <= rdata;
                                sda_oe_q <= ~rdata[7];
                                addr_q   <= next_rd;
                            end else begin
                                phase_q  <= PH_AHI;
                            end
                        end
                        PH_AHI: phase_q <= PH_ALO;
                        PH_ALO: phase_q <= PH_WDATA;
                        PH_RDATA: begin
                            if (m_ack_q) begin
                                shout_q  <= rdata;
                                sda_oe_q <= ~rdata[7];
                                addr_q   <= next_rd;
                            end else begin
                                phase_q  <= PH_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end else if (bit_q != 4'd0 && phase_q == PH_RDATA) begin
                    shout_q  <= {shout_q[6:0], 1'b0};
                    sda_oe_q <= ~shout_q[6];
                end
            end
        end
    end

    assign sda_oe = sda_oe_q;
endmodule

// File: rtl/eet_checker.sv
module eet_checker #(
    parameter int WCYC = 500000
) (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic sda_oe,
    input logic busy,
    input logic stop_det,
    input logic wr_inhibit
);
    int unsigned busy_len;

    always_ff @(posedge clk) begin
        if (rst)       busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    // R12: the data line is only touched while the clock line is low
    p_sda_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_s));

    // R5: no acknowledge while the write cycle runs
    p_busy_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_oe);

    // R5: the write cycle lasts exactly WCYC clocks
    p_wcycle_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == WCYC));

    // R4: a write cycle starts only on a Stop
    p_launch_stop_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_det));

    // R6: a write cycle never starts with the inhibit input high
    p_inhibit_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(wr_inhibit));
endmodule

bind eeprom_target eet_checker #(.WCYC(WCYC)) u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .busy(busy),
    .stop_det(stop_det), .wr_inhibit(wr_inhibit)
);

// File: tb/sim_eeprom_target.sv
module sim_eeprom_target;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 10;
    localparam int ADDR_W     = 11;
    localparam int WCYC       = 400;
    localparam logic [7:0] SEED = 8'hA5;
    localparam logic [2:0] CHIP = 3'b101;
    localparam logic [3:0] MAIN = 4'b1010;
    localparam logic [3:0] INFO = 4'b1011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic wr_inhibit = 1'b0;
    logic sda_oe, sda_bus;
    logic prev_oe = 1'b0;
    int   nchecks = 0, nerr = 0, r12_bad = 0;
    bit   done = 1'b0;
    logic [7:0] ref_mem [1 << ADDR_W];

    assign sda_bus = m_sda & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_target #(.ADDR_W(ADDR_W), .WCYC(WCYC), .UID_SEED(SEED)) u0 (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .chip_sel(CHIP), .wr_inhibit(wr_inhibit)
    );

    // R12 monitor: every clock, sda_oe may only change while the bench holds SCL low
    always @(negedge clk) begin
        if (!rst) begin
            if (sda_oe !== prev_oe && m_scl) r12_bad++;
            prev_oe = sda_oe;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    endtask

    function automatic logic [7:0] info_exp(input int i);
        logic [7:0] p;
        p = 8'(i * 8'h3B);
        return (i < 16) ? (p ^ SEED) : 8'hFF;
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);
        m_sda = 1'b0; wait_clk(HALF);
        m_scl = 1'b0; wait_clk(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);
        m_sda = 1'b1; wait_clk(HALF);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF);
        m_scl = 1'b0; wait_clk(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_sda = 1'b1; wait_clk(HALF);
        m_scl = 1'b1; wait_clk(HALF/2);
        ack = ~sda_bus; wait_clk(HALF/2);
        m_scl = 1'b0; wait_clk(2);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wait_clk(HALF);
            m_scl = 1'b1; wait_clk(HALF/2);
            b[i] = sda_bus; wait_clk(HALF/2);
            m_scl = 1'b0; wait_clk(2);
        end
        put_bit(~give_ack);
    endtask

    // Full write transaction; the model is updated only when a write cycle is due.
    task automatic wr_txn(input logic [3:0] sp, input logic [15:0] addr,
                          input logic [7:0] d [$], output logic all_ack);
        logic a;
        all_ack = 1'b1;
        bus_start();
        send_byte({sp, CHIP, 1'b0}, a); all_ack &= a;
        send_byte(addr[15:8], a);       all_ack &= a;
        send_byte(addr[7:0], a);        all_ack &= a;
        foreach (d[i]) begin send_byte(d[i], a); all_ack &= a; end
        bus_stop();
        if (sp == MAIN && !wr_inhibit && d.size() > 0)
            foreach (d[i]) ref_mem[{addr[ADDR_W-1:6], 6'(addr[5:0] + i)}] = d[i];
    endtask

    task automatic wait_ready(output int polls);
        logic a;
        polls = 0;
        forever begin
            bus_start();
            send_byte({MAIN, CHIP, 1'b0}, a);
            if (a || polls > 40) begin bus_stop(); break; end
            polls++;
        end
    endtask

    task automatic rd_txn(input logic [3:0] sp, input logic [15:0] addr, input int n,
                          output logic [7:0] q [$], output logic all_ack);
        logic a;
        logic [7:0] b;
        q = {};
        all_ack = 1'b1;
        bus_start();
        send_byte({sp, CHIP, 1'b0}, a); all_ack &= a;
        send_byte(addr[15:8], a);       all_ack &= a;
        send_byte(addr[7:0], a);        all_ack &= a;
        bus_start();
        send_byte({sp, CHIP, 1'b1}, a); all_ack &= a;
        for (int i = 0; i < n; i++) begin recv_byte(i < n-1, b); q.push_back(b); end
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic ack;
        logic [7:0] b;
        logic [7:0] q [$];
        int polls;
        foreach (ref_mem[i]) ref_mem[i] = 8'h00;
        wait_clk(5);
        check("R11 sda_oe after reset", sda_oe, 1'b0);
        rst = 1'b0;
        wait_clk(5);
        check("R11 sda_oe idle", sda_oe, 1'b0);

        // R1: wrong strap and wrong space code are ignored
        bus_start(); send_byte({MAIN, 3'b010, 1'b0}, ack); bus_stop();
        check("R1 wrong chip select", ack, 1'b0);
        bus_start(); send_byte({4'b1100, CHIP, 1'b0}, ack); bus_stop();
        check("R1 wrong space code", ack, 1'b0);

        // R2/R5: byte write and polling
        wr_txn(MAIN, 16'h0123, '{8'h5A}, ack);
        check("R2 write select/address/data ack", ack, 1'b1);
        wait_ready(polls);
        check("R5 first poll unacknowledged", polls > 0, 1'b1);
        check("R5 ack returns after cycle", polls < 10, 1'b1);
        rd_txn(MAIN, 16'h0123, 1, q, ack);
        check("R8 random read ack", ack, 1'b1);
        check("R8 random read data", q[0], ref_mem[11'h123]);

        // R3: page write rolling over within the page
        wr_txn(MAIN, 16'h02FE, '{8'h11, 8'h22, 8'h33}, ack);
        wait_ready(polls);
        rd_txn(MAIN, 16'h02C0, 1, q, ack);
        check("R3 page rollover byte", q[0], 8'h33);
        check("R3 model agrees", ref_mem[11'h2C0], 8'h33);
        rd_txn(MAIN, 16'h02FE, 2, q, ack);
        check("R10 sequential first", q[0], 8'h11);
        check("R10 sequential second", q[1], 8'h22);

        // R9: current-address read after one byte
        rd_txn(MAIN, 16'h02FE, 1, q, ack);
        bus_start(); send_byte({MAIN, CHIP, 1'b1}, ack); recv_byte(1'b0, b); bus_stop();
        check("R9 current address ack", ack, 1'b1);
        check("R9 current address data", b, ref_mem[11'h2FF]);

        // R9: wrap from the last address to 0
        wr_txn(MAIN, 16'h07FF, '{8'hC3}, ack); wait_ready(polls);
        wr_txn(MAIN, 16'h0000, '{8'h3C}, ack); wait_ready(polls);
        rd_txn(MAIN, 16'h07FF, 2, q, ack);
        check("R9 last address", q[0], 8'hC3);
        check("R9 wrap to zero", q[1], 8'h3C);

        // R6: inhibit blocks the write cycle
        wr_inhibit = 1'b1;
        wr_txn(MAIN, 16'h0123, '{8'h99}, ack);
        wait_ready(polls);
        check("R6 no cycle when inhibited", polls, 0);
        wr_inhibit = 1'b0;
        rd_txn(MAIN, 16'h0123, 1, q, ack);
        check("R6 contents unchanged", q[0], 8'h5A);

        // R7: information page is read-only
        wr_txn(INFO, 16'h0005, '{8'h00}, ack);
        wait_ready(polls);
        check("R7 no cycle for info write", polls, 0);
        rd_txn(INFO, 16'h0005, 1, q, ack);
        check("R7 uid byte 5", q[0], info_exp(5));
        rd_txn(INFO, 16'h000F, 2, q, ack);
        check("R7 uid byte 15", q[0], info_exp(15));
        check("R7 page byte 16", q[1], info_exp(16));
        rd_txn(INFO, 16'h003F, 2, q, ack);
        check("R9 info wraps in page", q[1], info_exp(0));

        // R8: read select must repeat the dummy write select
        bus_start();
        send_byte({MAIN, CHIP, 1'b0}, ack);
        send_byte(8'h00, ack);
        send_byte(8'h10, ack);
        bus_start();
        send_byte({INFO, CHIP, 1'b1}, ack);
        bus_stop();
        check("R8 mismatched read select", ack, 1'b0);

        // R4: restart after data discards it
        bus_start();
        send_byte({MAIN, CHIP, 1'b0}, ack);
        send_byte(8'h01, ack);
        send_byte(8'h23, ack);
        send_byte(8'h77, ack);
        bus_start();
        send_byte({MAIN, CHIP, 1'b1}, ack);
        check("R8 matched read select after restart", ack, 1'b1);
        recv_byte(1'b0, b);
        bus_stop();
        wait_ready(polls);
        check("R4 no cycle after restart", polls, 0);
        rd_txn(MAIN, 16'h0123, 1, q, ack);
        check("R4 discarded data", q[0], 8'h5A);

        check("R12 sda changes with scl high", r12_bad, 0);
        done = 1'b1;
        summary();
    end
endmodule